// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one whole NAND flash operation each time software asks for one. Software first fills a small set of registers: the low and high address words, a transfer length, an optional confirm opcode, and three strobe timing values. It then writes a control word whose top bit starts the engine. The engine drives an 8-bit flash bus through the sequence. It issues the opening command with CLE high, then a chosen number of address bytes with ALE high. A program operation moves its data burst out of a local byte buffer next. It then issues the optional confirm opcode. After a fixed guard delay the engine waits for the ready/busy line to show ready. A read operation moves its data burst into the buffer only after ready is seen.

Completion raises a sticky status flag. Reads raise a second flag when the last byte has landed in the buffer. Software clears each flag by writing a one to it. A mask register chooses which flags reach the interrupt pin. The host side reaches the byte buffer through its own write port and its own read port. Program data is placed there before the operation starts, and read data is collected there after the operation ends.

Register word indices on `reg_addr`: 0 control (write only), 1 confirm, 2 flag status, 3 flag mask, 4 length, 5 low address, 6 high address, 7 strobe low width, 8 strobe high width, 9 guard delay, 10 engine status.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the engine is idle. Chip enable, WE# and RE# are high, CLE and ALE are low, and the interrupt pin is low. The flag status, the mask and the engine status read zero, and the three timing registers read all ones.
- R2: A write to the control register with bit 31 set starts an operation only while the engine is idle. Such a write while busy, or any control write with bit 31 clear, has no effect. Engine status bit 0 reads 1 while an operation runs, and chip enable stays low for that whole time.
- R3: Control bits 7:0 are the opening opcode. It is the first byte of every operation and is sent with CLE high, latched on the rising edge of WE#.
- R4: Control bit 30 enables the address phase and bits 29:27 hold the byte count minus one. Address bytes are taken from the 40-bit value {high register bits 23:0, low register bits 15:0}, least significant byte first, and bytes past the fifth are zero. Each address byte is sent with ALE high.
- R5: Control bit 26 selects a read burst and bit 25 selects a write burst. Bit 26 wins when both are set. A write burst follows the address phase. A read burst follows the ready wait.
- R6: The length register value L moves exactly L+1 bytes. The buffer pointer restarts at 0 for every operation. With one address byte and L=4, a read returns five bytes, which is the shape of an identify or status read.
- R7: When confirm register bit 8 is set, its bits 7:0 are sent with CLE high after the address phase and after any write burst.
- R8: After the last command or address byte the engine counts the guard delay (register value plus one cycles). It then waits for ready/busy high and does not raise the completion flag while the device is busy.
- R9: Flag status bit 31 sets when an operation completes and bit 28 sets when a read burst finishes. Writing a one to either bit clears it, and a new set wins over a clear in the same cycle.
- R10: The interrupt pin is high when a flag is set and its mask bit (31 or 28) is set.
- R11: Each WE#/RE# strobe stays low for exactly (low width + 1) cycles and high for at least (high width + 1) cycles, so the all-ones reset values give the slowest bus timing.
- R12: Host buffer writes land where the engine reads program data, and the host read port returns the bytes a read burst stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_buf_we | input | 1 | Host buffer write enable |
| host_buf_waddr | input | BUF_AW | Host buffer write address |
| host_buf_wdata | input | 8 | Host buffer write data |
| host_buf_raddr | input | BUF_AW | Host buffer read address |
| host_buf_rdata | output | 8 | Host buffer read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_n | input | 1 | Ready/busy, high when ready |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps every address count from none to five across no-data, read and write operations. It alternates whether the confirm opcode is armed and varies the length at each step. An off-by-one in the length would show up as one byte too many or too few at the bus model. An address byte taken in the wrong order, or from the wrong end, would show up as a mismatched byte. A confirm byte placed before the write burst would reorder the command log. The bench also starts an operation while one is running and sets both direction bits together. A design that accepted the second start would emit an extra opcode, and one that honoured the write bit would drive data out during a read. Partial flag clears, masking, and strobe widths at both the slowest and fast timings are measured at the pins. A design that raised completion while ready/busy was still low is caught by the bus model.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    // register word indices
    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_CONF   = 4'd1;
    localparam logic [3:0] RA_FLAGS  = 4'd2;
    localparam logic [3:0] RA_MASK   = 4'd3;
    localparam logic [3:0] RA_LEN    = 4'd4;
    localparam logic [3:0] RA_ADDRLO = 4'd5;
    localparam logic [3:0] RA_ADDRHI = 4'd6;
    localparam logic [3:0] RA_TLOW   = 4'd7;
    localparam logic [3:0] RA_THIGH  = 4'd8;
    localparam logic [3:0] RA_TGUARD = 4'd9;
    localparam logic [3:0] RA_STAT   = 4'd10;

    // control word fields
    localparam int CTL_GO   = 31;
    localparam int CTL_AEN  = 30;
    localparam int CTL_ACNT = 27;
    localparam int CTL_RD   = 26;
    localparam int CTL_WR   = 25;
    localparam int CONF_EN  = 8;

    // flag bits
    localparam int FLG_DONE = 31;
    localparam int FLG_RDAT = 28;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2,
        ST_GUARD, ST_WAITRDY, ST_RDATA, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} strobe_phase_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd;
        logic       wr;
        logic       addr_en;
        logic [2:0] addr_last;
        logic       conf_en;
        logic [7:0] conf_op;
    } nand_op_t;

    function automatic nand_op_t decode_op(input logic [31:0] ctl, input logic [8:0] conf);
        nand_op_t op;
        op.opcode    = ctl[7:0];
        op.rd        = ctl[CTL_RD];
        op.wr        = ctl[CTL_WR] & ~ctl[CTL_RD];
        op.addr_en   = ctl[CTL_AEN];
        op.addr_last = ctl[CTL_ACNT +: 3];
        op.conf_en   = conf[CONF_EN];
        op.conf_op   = conf[7:0];
        return op;
    endfunction

    function automatic logic [7:0] addr_byte(input logic [15:0] lo, input logic [23:0] hi,
                                             input logic [2:0] idx);
        logic [63:0] w;
        w = {24'd0, hi, lo};
        return w[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe
    import nseq_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [TW-1:0] low_w_i,
    input  logic [TW-1:0] high_w_i,
    output logic          strobe_n_o,
    output logic          low_last_o,
    output logic          done_o
);

    strobe_phase_e ph_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start_i) begin
                    ph_q  <= PH_LOW;
                    cnt_q <= low_w_i;
                end
                PH_LOW: if (cnt_q == '0) begin
                    ph_q  <= PH_HIGH;
                    cnt_q <= high_w_i;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_HIGH: if (cnt_q == '0) begin
                    ph_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign strobe_n_o = (ph_q != PH_LOW);
    assign low_last_o = (ph_q == PH_LOW) && (cnt_q == '0);
    assign done_o     = (ph_q == PH_HIGH) && (cnt_q == '0);

    // R11: a new strobe is only requested once the previous one has fully recovered
    a_r11_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (ph_q == PH_IDLE));

endmodule

// File: rtl/nseq_buf.sv
module nseq_buf #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [7:0]    host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [7:0]    host_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end else if (host_we) begin
            mem[host_waddr] <= host_wdata;
        end
    end

    assign host_rdata = mem[host_raddr];
    assign eng_rdata  = mem[eng_addr];

endmodule

// File: rtl/nseq_regs.sv
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int AW = 6,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          busy_i,
    input  logic          set_done_i,
    input  logic          set_rdat_i,
    output logic          start_o,
    output logic [8:0]    conf_o,
    output logic [AW-1:0] len_o,
    output logic [15:0]   alo_o,
    output logic [23:0]   ahi_o,
    output logic [TW-1:0] tlow_o,
    output logic [TW-1:0] thigh_o,
    output logic [TW-1:0] tguard_o,
    output logic          irq_o
);

    logic done_q, rdat_q, mdone_q, mrdat_q;
    logic clr_done, clr_rdat;

    assign clr_done = wr_en && (addr == RA_FLAGS) && wdata[FLG_DONE];
    assign clr_rdat = wr_en && (addr == RA_FLAGS) && wdata[FLG_RDAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            conf_o   <= '0;
            len_o    <= '0;
            alo_o    <= '0;
            ahi_o    <= '0;
            tlow_o   <= '1;
            thigh_o  <= '1;
            tguard_o <= '1;
            mdone_q  <= 1'b0;
            mrdat_q  <= 1'b0;
            done_q   <= 1'b0;
            rdat_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    RA_CONF:   conf_o   <= wdata[8:0];
                    RA_LEN:    len_o    <= wdata[AW-1:0];
                    RA_ADDRLO: alo_o    <= wdata[15:0];
                    RA_ADDRHI: ahi_o    <= wdata[23:0];
                    RA_TLOW:   tlow_o   <= wdata[TW-1:0];
                    RA_THIGH:  thigh_o  <= wdata[TW-1:0];
                    RA_TGUARD: tguard_o <= wdata[TW-1:0];
                    RA_MASK: begin
                        mdone_q <= wdata[FLG_DONE];
                        mrdat_q <= wdata[FLG_RDAT];
                    end
                    default: ;
                endcase
            end
            done_q <= set_done_i | (done_q & ~clr_done);
            rdat_q <= set_rdat_i | (rdat_q & ~clr_rdat);
        end
    end

    assign start_o = wr_en && (addr == RA_CTRL) && wdata[CTL_GO] && !busy_i;
    assign irq_o   = (done_q & mdone_q) | (rdat_q & mrdat_q);

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CONF:   rdata[8:0]     = conf_o;
            RA_FLAGS: begin
                rdata[FLG_DONE] = done_q;
                rdata[FLG_RDAT] = rdat_q;
            end
            RA_MASK: begin
                rdata[FLG_DONE] = mdone_q;
                rdata[FLG_RDAT] = mrdat_q;
            end
            RA_LEN:    rdata[AW-1:0]  = len_o;
            RA_ADDRLO: rdata[15:0]    = alo_o;
            RA_ADDRHI: rdata[23:0]    = ahi_o;
            RA_TLOW:   rdata[TW-1:0]  = tlow_o;
            RA_THIGH:  rdata[TW-1:0]  = thigh_o;
            RA_TGUARD: rdata[TW-1:0]  = tguard_o;
            RA_STAT:   rdata[0]       = busy_i;
            default:   rdata          = '0;
        endcase
    end

    // R9: a one written to the completion flag clears it unless a new completion arrives
    a_r9_w1c_done: assert property (@(posedge clk) disable iff (rst)
        (clr_done && !set_done_i) |=> !done_q);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int BUF_AW = 6,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              host_buf_we,
    input  logic [BUF_AW-1:0] host_buf_waddr,
    input  logic [7:0]        host_buf_wdata,
    input  logic [BUF_AW-1:0] host_buf_raddr,
    output logic [7:0]        host_buf_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n,
    output logic              irq
);

    seq_state_e        st_q;
    nand_op_t          op_q;
    logic              kick_q;
    logic [2:0]        aidx_q;
    logic [BUF_AW-1:0] ptr_q, cnt_q, len_q;
    logic [TW-1:0]     guard_q;
    logic [15:0]       alo_q;
    logic [23:0]       ahi_q;

    logic              busy, start;
    logic [8:0]        conf;
    logic [BUF_AW-1:0] len;
    logic [15:0]       alo;
    logic [23:0]       ahi;
    logic [TW-1:0]     tlow, thigh, tguard;
    logic              strobe_n, low_last, sdone;
    logic              set_done, set_rdat;
    logic              eng_we;
    logic [7:0]        eng_rdata;
    seq_state_e        post_addr;
    logic              post_kick;

    assign busy = (st_q != ST_IDLE);

    nseq_regs #(.AW(BUF_AW), .TW(TW)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy_i    (busy),
        .set_done_i(set_done),
        .set_rdat_i(set_rdat),
        .start_o   (start),
        .conf_o    (conf),
        .len_o     (len),
        .alo_o     (alo),
        .ahi_o     (ahi),
        .tlow_o    (tlow),
        .thigh_o   (thigh),
        .tguard_o  (tguard),
        .irq_o     (irq)
    );

    nseq_strobe #(.TW(TW)) i_strobe (
        .clk       (clk),
        .rst       (rst),
        .start_i   (kick_q),
        .low_w_i   (tlow),
        .high_w_i  (thigh),
        .strobe_n_o(strobe_n),
        .low_last_o(low_last),
        .done_o    (sdone)
    );

    nseq_buf #(.AW(BUF_AW)) i_buf (
        .clk       (clk),
        .host_we   (host_buf_we),
        .host_waddr(host_buf_waddr),
        .host_wdata(host_buf_wdata),
        .host_raddr(host_buf_raddr),
        .host_rdata(host_buf_rdata),
        .eng_we    (eng_we),
        .eng_addr  (ptr_q),
        .eng_wdata (nand_dq_i),
        .eng_rdata (eng_rdata)
    );

    // state reached once the address phase (or the opening command) ends
    always_comb begin
        if (op_q.wr) begin
            post_addr = ST_WDATA;
            post_kick = 1'b1;
        end else if (op_q.conf_en) begin
            post_addr = ST_CMD2;
            post_kick = 1'b1;
        end else begin
            post_addr = ST_GUARD;
            post_kick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= '0;
            kick_q  <= 1'b0;
            aidx_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            guard_q <= '0;
            alo_q   <= '0;
            ahi_q   <= '0;
        end else begin
            kick_q <= 1'b0;
            if (st_q != ST_GUARD) begin
                guard_q <= tguard;
            end else if (guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
            case (st_q)
                ST_IDLE: if (start) begin
                    op_q   <= decode_op(reg_wdata, conf);
                    st_q   <= ST_CMD1;
                    kick_q <= 1'b1;
                    ptr_q  <= '0;
                    aidx_q <= '0;
                    cnt_q  <= len;
                    len_q  <= len;
                    alo_q  <= alo;
                    ahi_q  <= ahi;
                end
                ST_CMD1: if (sdone) begin
                    if (op_q.addr_en) begin
                        st_q   <= ST_ADDR;
                        kick_q <= 1'b1;
                    end else begin
                        st_q   <= post_addr;
                        kick_q <= post_kick;
                    end
                end
                ST_ADDR: if (sdone) begin
                    if (aidx_q == op_q.addr_last) begin
                        st_q   <= post_addr;
                        kick_q <= post_kick;
                    end else begin
                        aidx_q <= aidx_q + 1'b1;
                        kick_q <= 1'b1;
                    end
                end
                ST_WDATA: if (sdone) begin
                    ptr_q <= ptr_q + 1'b1;
                    if (cnt_q == '0) begin
                        st_q   <= op_q.conf_en ? ST_CMD2 : ST_GUARD;
                        kick_q <= op_q.conf_en;
                    end else begin
                        cnt_q  <= cnt_q - 1'b1;
                        kick_q <= 1'b1;
                    end
                end
                ST_CMD2: if (sdone) begin
                    st_q <= ST_GUARD;
                end
                ST_GUARD: if (guard_q == '0) begin
                    st_q <= ST_WAITRDY;
                end
                ST_WAITRDY: if (nand_rb_n) begin
                    if (op_q.rd) begin
                        st_q   <= ST_RDATA;
                        kick_q <= 1'b1;
                    end else begin
                        st_q <= ST_DONE;
                    end
                end
                ST_RDATA: if (sdone) begin
                    ptr_q <= ptr_q + 1'b1;
                    if (cnt_q == '0) begin
                        st_q <= ST_DONE;
                    end else begin
                        cnt_q  <= cnt_q - 1'b1;
                        kick_q <= 1'b1;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign set_done = (st_q == ST_DONE);
    assign set_rdat = (st_q == ST_RDATA) && sdone && (cnt_q == '0);
    assign eng_we   = (st_q == ST_RDATA) && low_last;

    // bus outputs
    assign nand_ce_n  = !busy;
    assign nand_cle   = (st_q == ST_CMD1) || (st_q == ST_CMD2);
    assign nand_ale   = (st_q == ST_ADDR);
    assign nand_dq_oe = nand_cle || nand_ale || (st_q == ST_WDATA);
    assign nand_we_n  = nand_dq_oe ? strobe_n : 1'b1;
    assign nand_re_n  = (st_q == ST_RDATA) ? strobe_n : 1'b1;

    always_comb begin
        case (st_q)
            ST_CMD1:  nand_dq_o = op_q.opcode;
            ST_CMD2:  nand_dq_o = op_q.conf_op;
            ST_ADDR:  nand_dq_o = addr_byte(alo_q, ahi_q, aidx_q);
            ST_WDATA: nand_dq_o = eng_rdata;
            default:  nand_dq_o = 8'h00;
        endcase
    end

    // R5: write and read strobes never overlap
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R2: a bus strobe only happens with the chip selected
    a_r2_ce_during_strobe: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R6: a burst moves length+1 bytes, so the pointer ends there
    a_r6_burst_count: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_DONE) && (op_q.rd || op_q.wr)) |-> (ptr_q == BUF_AW'(len_q + 1'b1)));

    // R8: completion of an operation without read burst follows a ready sample
    a_r8_done_after_ready: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_DONE) && !op_q.rd) |-> $past(nand_rb_n));

endmodule

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_AW     = 6;
    localparam int TW         = 4;
    localparam int BUSY_CYC   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              host_buf_we = 1'b0;
    logic [BUF_AW-1:0] host_buf_waddr = '0;
    logic [7:0]        host_buf_wdata = '0;
    logic [BUF_AW-1:0] host_buf_raddr = '0;
    logic [7:0]        host_buf_rdata;
    logic              nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]        nand_dq_o;
    logic [7:0]        nand_dq_i = '0;
    logic              nand_rb_n;
    logic              irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cmd_seq #(.BUF_AW(BUF_AW), .TW(TW)) i_nand_cmd_seq (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_buf_we(host_buf_we), .host_buf_waddr(host_buf_waddr), .host_buf_wdata(host_buf_wdata),
        .host_buf_raddr(host_buf_raddr), .host_buf_rdata(host_buf_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n), .irq(irq)
    );

    // ---------------- flash bus model (acts at falling clock edges) ----------------
    logic [7:0] cmd_log [8];
    logic [7:0] adr_log [8];
    logic [7:0] wd_log  [64];
    int ncmd, nadr, nwd, rcnt, busy_cnt, cur_low, low_min, low_max, early;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] rd_seed;

    assign nand_rb_n = (busy_cnt == 0);

    function automatic logic [7:0] rpat(input int k, input logic [7:0] seed);
        return 8'(k * 7 + 8'h3C) ^ seed;
    endfunction

    function automatic logic [7:0] wpat(input int k, input int op);
        return 8'(k * 13 + op * 5 + 1);
    endfunction

    task automatic clear_log();
        ncmd = 0; nadr = 0; nwd = 0; rcnt = 0; early = 0;
        low_min = 1000; low_max = 0; cur_low = 0;
    endtask

    initial begin
        busy_cnt = 0;
        clear_log();
    end

    always @(negedge clk) begin
        if (!nand_we_n || !nand_re_n) begin
            cur_low = cur_low + 1;
        end else if (cur_low != 0) begin
            if (cur_low < low_min) low_min = cur_low;
            if (cur_low > low_max) low_max = cur_low;
            cur_low = 0;
        end
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!prev_we && nand_we_n) begin
            if (nand_cle) begin
                if (ncmd < 8) cmd_log[ncmd] = nand_dq_o;
                ncmd = ncmd + 1;
                busy_cnt = BUSY_CYC;
            end else if (nand_ale) begin
                if (nadr < 8) adr_log[nadr] = nand_dq_o;
                nadr = nadr + 1;
            end else begin
                if (nwd < 64) wd_log[nwd] = nand_dq_o;
                nwd = nwd + 1;
            end
        end
        if (prev_re && !nand_re_n) begin
            nand_dq_i = rpat(rcnt, rd_seed);
            rcnt = rcnt + 1;
        end
        if (irq && busy_cnt != 0) early = 1;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic buf_fill(input int n, input int op);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_buf_we = 1'b1; host_buf_waddr = BUF_AW'(i); host_buf_wdata = wpat(i, op);
        end
        @(negedge clk);
        host_buf_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(4'd10, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    function automatic logic [31:0] ctl_word(input logic [7:0] opc, input int ac, input int mode);
        logic [31:0] w;
        w = 32'h8000_0000 | {24'd0, opc};
        if (ac > 0) w = w | 32'h4000_0000 | (32'(ac - 1) << 27);
        if (mode == 1) w = w | 32'h0400_0000;
        if (mode == 2) w = w | 32'h0200_0000;
        if (mode == 3) w = w | 32'h0600_0000;
        return w;
    endfunction

    // run one operation and check everything visible at the pins
    task automatic run_and_check(input int op, input int ac, input int mode, input int dl,
                                 input int c2, input int tl);
        logic [31:0] s;
        logic [15:0] alo;
        logic [23:0] ahi;
        logic [63:0] aw;
        logic [7:0]  opc, cop;
        int errs;
        logic rdm;
        rdm = (mode == 1 || mode == 3);
        opc = 8'(8'h20 + op);
        cop = 8'(8'hC0 + op);
        alo = 16'(16'h1234 + op * 16'h0111);
        ahi = 24'(24'hA1B2C3 ^ (op * 24'h010203));
        aw  = {24'd0, ahi, alo};
        rd_seed = 8'(op);
        if (mode == 2) buf_fill(dl + 1, op);
        reg_write(4'd5, {16'd0, alo});
        reg_write(4'd6, {8'd0, ahi});
        reg_write(4'd4, 32'(dl));
        reg_write(4'd1, {23'd0, c2[0], cop});
        reg_write(4'd2, 32'hFFFF_FFFF);
        clear_log();
        reg_write(4'd0, ctl_word(opc, ac, mode));
        wait_idle();
        repeat (3) @(negedge clk);
        check(ncmd == 1 + c2, "R7", ncmd, 1 + c2);
        check(cmd_log[0] == opc, "R3", cmd_log[0], opc);
        if (c2 != 0) check(cmd_log[1] == cop, "R7", cmd_log[1], cop);
        errs = 0;
        for (int i = 0; i < ac; i++) if (adr_log[i] != aw[8*i +: 8]) errs++;
        check(nadr == ac && errs == 0, "R4", nadr * 256 + errs, ac * 256);
        if (mode == 2) begin
            errs = 0;
            for (int i = 0; i <= dl; i++) if (wd_log[i] != wpat(i, op)) errs++;
            check(nwd == dl + 1 && errs == 0, "R12", nwd * 256 + errs, (dl + 1) * 256);
        end else begin
            check(nwd == 0, "R5", nwd, 0);
        end
        if (rdm) begin
            errs = 0;
            for (int i = 0; i <= dl; i++) begin
                @(negedge clk);
                host_buf_raddr = BUF_AW'(i);
                #1;
                if (host_buf_rdata != rpat(i, 8'(op))) errs++;
            end
            check(rcnt == dl + 1, "R6", rcnt, dl + 1);
            check(errs == 0, "R12", errs, 0);
        end else begin
            check(rcnt == 0, "R5", rcnt, 0);
        end
        reg_read(4'd2, s);
        check(s == {1'b1, 2'b00, rdm, 28'd0}, "R9", s, {1'b1, 2'b00, rdm, 28'd0});
        check(early == 0, "R8", early, 0);
        check(low_min == tl + 1 && low_max == tl + 1, "R11", low_min * 1000 + low_max,
              (tl + 1) * 1001);
    endtask

    initial begin
        logic [31:0] d;
        int op;
        op = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !irq, "R1",
              {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, irq}, 6'b111000);
        reg_read(4'd2, d);  check(d == 0, "R1", d, 0);
        reg_read(4'd3, d);  check(d == 0, "R1", d, 0);
        reg_read(4'd10, d); check(d == 0, "R1", d, 0);
        reg_read(4'd7, d);  check(d == 32'hF, "R1", d, 32'hF);
        reg_read(4'd9, d);  check(d == 32'hF, "R1", d, 32'hF);

        // R2: control write without the go bit does nothing
        clear_log();
        reg_write(4'd0, 32'h4400_0090);
        repeat (20) @(negedge clk);
        reg_read(4'd10, d);
        check(d[0] == 1'b0 && ncmd == 0 && nand_ce_n, "R2", ncmd, 0);

        // R11 slowest timing at reset defaults; mask off so irq checked later
        op++;
        run_and_check(op, 2, 2, 3, 1, 15);
        // R10: masked flags keep irq low
        check(irq == 1'b0, "R10", irq, 0);
        reg_write(4'd3, 32'h8000_0000);
        @(negedge clk);
        check(irq == 1'b1, "R10", irq, 1);
        reg_write(4'd2, 32'h8000_0000);
        @(negedge clk);
        check(irq == 1'b0, "R10", irq, 0);
        reg_write(4'd3, 32'h9000_0000);

        // fast timing for the sweep
        reg_write(4'd7, 32'd1);
        reg_write(4'd8, 32'd0);
        reg_write(4'd9, 32'd2);
        for (int mode = 0; mode < 3; mode++) begin
            for (int ac = 0; ac <= 5; ac++) begin
                op++;
                run_and_check(op, ac, mode, (ac * 5 + mode * 3 + 1) % 16, ac % 2, 1);
            end
        end

        // R6: identify-style read, one address byte, length 4
        op++;
        run_and_check(op, 1, 1, 4, 0, 1);
        // R5: both direction bits, read wins
        op++;
        run_and_check(op, 3, 3, 6, 1, 1);
        // long burst covering whole buffer
        op++;
        run_and_check(op, 5, 1, 63, 0, 1);

        // R9: partial clear of flags after a read
        reg_write(4'd2, 32'h8000_0000);
        reg_read(4'd2, d);
        check(d == 32'h1000_0000, "R9", d, 32'h1000_0000);
        check(irq == 1'b1, "R10", irq, 1);
        reg_write(4'd2, 32'h1000_0000);
        reg_read(4'd2, d);
        check(d == 0, "R9", d, 0);

        // R2: a start while busy is ignored
        clear_log();
        reg_write(4'd1, 32'h0000_0110);
        reg_write(4'd4, 32'd3);
        reg_write(4'd0, 32'hC000_0060);
        reg_write(4'd0, 32'h8000_0077);
        reg_read(4'd10, d);
        check(d[0] == 1'b1, "R2", d, 1);
        wait_idle();
        repeat (3) @(negedge clk);
        check(ncmd == 2 && cmd_log[0] == 8'h60 && cmd_log[1] == 8'h10, "R2",
              {ncmd[7:0], cmd_log[0], cmd_log[1]}, {8'd2, 8'h60, 8'h10});
        check(nadr == 1, "R4", nadr, 1);
        check(nand_ce_n == 1'b1, "R2", nand_ce_n, 1);

        finish_up();
    end

endmodule